// File: doc/BRIEF.md
# DDR Refresh Scheduler with Bounded Postponement

This block decides when a DDR SDRAM controller must issue AUTO REFRESH commands. A free-running interval counter adds one owed refresh each refresh period, and each granted refresh pays one back. Because the scheduler keeps a count of owed refreshes instead of firing on a fixed period, the command arbiter can put refreshes off while it is busy with traffic. The debt is capped at eight postponed refreshes. Once the debt comes close to that cap, the request turns urgent and new row activations are held off until the debt is paid down.

Each refresh runs as a fixed sequence. First the scheduler asks for all banks to be precharged. It then waits until the banks are reported idle and raises a refresh request to the arbiter. When the arbiter grants the request, the scheduler blocks every other command for the refresh cycle time while CKE stays high. The block can also put the memory into self-refresh by dropping CKE. When self-refresh ends, the block clears the debt and enforces the two exit windows: one for non-read commands and a longer one for reads.

The request, grant and bank-idle signals are plain level handshakes and carry no data. A request is held until the matching condition is seen at a clock edge: bank-idle for the precharge-all request, and grant for the refresh request. The arbiter applies back-pressure simply by keeping grant low. All outputs are decoded from registered state, so none of them depends combinationally on an input.

Top module: `refresh_sched`

## Requirements
- R1: After reset, pre_req, ref_req, ref_urgent, act_block, cmd_block and read_block are all low and cke is high.
- R2: Outside self-refresh, one refresh becomes owed every INTERVAL_CYC cycles. When the scheduler is idle, no block window is open and at least one refresh is owed, pre_req rises in the next cycle.
- R3: pre_req stays high until banks_idle is sampled high at a clock edge. ref_req then rises in the next cycle and stays high until ref_gnt is sampled high. pre_req and ref_req are never high together.
- R4: A grant accepted while ref_req is high removes one owed refresh. If a new refresh becomes owed in the same cycle as a grant, the owed count does not change.
- R5: The owed count saturates at DEBT_MAX (8). A period that ends while the count is already 8 adds nothing.
- R6: While the owed count is at least URGENT_AT (7) and the block is not in self-refresh, act_block is high. ref_urgent is high exactly when that condition holds and pre_req or ref_req is also high.
- R7: After an accepted grant, cmd_block is high for exactly TRFC_CYC cycles with cke high. During that time pre_req and ref_req stay low.
- R8: ref_gnt has no effect while ref_req is low.
- R9: sr_enter sampled while idle with no window open raises pre_req. Once banks_idle is then sampled high, cke goes low and stays low until exit. While cke is low, no refresh becomes owed and no request is raised.
- R10: sr_exit sampled during self-refresh raises cke in the next cycle and clears the owed count and the interval phase. cmd_block is then high for XSNR_CYC cycles and read_block for XSRD_CYC cycles.
- R11: sr_exit has no effect outside self-refresh, and sr_enter has no effect while a precharge or refresh request is pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| banks_idle | input | 1 | All banks reported precharged |
| ref_gnt | input | 1 | Arbiter accepts the refresh request |
| sr_enter | input | 1 | Request to enter self-refresh |
| sr_exit | input | 1 | Request to leave self-refresh |
| pre_req | output | 1 | Precharge-all request |
| ref_req | output | 1 | AUTO REFRESH request |
| ref_urgent | output | 1 | Pending request is urgent |
| act_block | output | 1 | Hold off new activates |
| cmd_block | output | 1 | No command may be issued |
| read_block | output | 1 | No read may be issued |
| cke | output | 1 | Clock enable level for the memory |

## Verification
The bench keeps the grant low for more than eight periods so that the owed count hits its cap, then drains it. A design without saturation, or with a wrong urgent threshold, would raise too many refreshes or raise ref_urgent in the wrong cycle. The bench also holds ref_gnt high while no request is pending, where a design that accepted stray grants would open a refresh window with no refresh behind it. Pulses on the self-refresh controls in the wrong states, and an exit followed by a long run, expose a design that keeps stale debt after exit, or that mis-times the non-read window or the read window.

// File: rtl/refresh_pkg.sv
package refresh_pkg;
  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_PRE   = 3'd1,
    ST_REQ   = 3'd2,
    ST_SRPRE = 3'd3,
    ST_SELF  = 3'd4
  } rs_state_t;
endpackage

// File: rtl/rs_tick.sv
module rs_tick #(
  parameter int INTERVAL_CYC = 1040
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  input  logic clear,
  output logic tick
);
  localparam int W = (INTERVAL_CYC > 2) ? $clog2(INTERVAL_CYC) : 1;
  localparam logic [W-1:0] LAST = W'(INTERVAL_CYC - 1);

  logic [W-1:0] cnt;

  assign tick = run && (cnt == LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt <= '0;
    else if (clear) cnt <= '0;
    else if (run) cnt <= tick ? '0 : cnt + 1'b1;
  end
endmodule

// File: rtl/rs_debt.sv
module rs_debt #(
  parameter int DEBT_MAX  = 8,
  parameter int URGENT_AT = 7
) (
  input  logic clk,
  input  logic rst_n,
  input  logic inc,
  input  logic dec,
  input  logic clear,
  output logic owed,
  output logic urgent
);
  localparam int W = $clog2(DEBT_MAX + 1);
  localparam logic [W-1:0] TOP = W'(DEBT_MAX);
  localparam logic [W-1:0] URG = W'(URGENT_AT);

  logic [W-1:0] debt;

  assign owed   = (debt != '0);
  assign urgent = (debt >= URG);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) debt <= '0;
    else if (clear) debt <= '0;
    else begin
      case ({inc, dec})
        2'b10: if (debt != TOP) debt <= debt + 1'b1;
        2'b01: if (debt != '0) debt <= debt - 1'b1;
        default: debt <= debt;
      endcase
    end
  end
endmodule

// File: rtl/rs_window.sv
module rs_window #(
  parameter int LEN = 10
) (
  input  logic clk,
  input  logic rst_n,
  input  logic load,
  output logic busy
);
  localparam int W = $clog2(LEN + 1);

  logic [W-1:0] cnt;

  assign busy = (cnt != '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt <= '0;
    else if (load) cnt <= W'(LEN);
    else if (busy) cnt <= cnt - 1'b1;
  end
endmodule

// File: rtl/refresh_sched.sv
module refresh_sched
  import refresh_pkg::*;
#(
  parameter int INTERVAL_CYC = 1040,
  parameter int DEBT_MAX     = 8,
  parameter int URGENT_AT    = 7,
  parameter int TRFC_CYC     = 10,
  parameter int XSNR_CYC     = 10,
  parameter int XSRD_CYC     = 200
) (
  input  logic clk,
  input  logic rst_n,
  input  logic banks_idle,
  input  logic ref_gnt,
  input  logic sr_enter,
  input  logic sr_exit,
  output logic pre_req,
  output logic ref_req,
  output logic ref_urgent,
  output logic act_block,
  output logic cmd_block,
  output logic read_block,
  output logic cke
);
  rs_state_t state, state_nx;
  logic tick, owed, urgent_lvl, grant, sr_leave;
  logic rfc_busy, xsnr_busy, xsrd_busy, quiet;

  assign grant    = (state == ST_REQ) && ref_gnt;
  assign sr_leave = (state == ST_SELF) && sr_exit;
  assign quiet    = !rfc_busy && !xsnr_busy;

  rs_tick #(.INTERVAL_CYC(INTERVAL_CYC)) u_tick (
    .clk(clk), .rst_n(rst_n), .run(state != ST_SELF), .clear(sr_leave), .tick(tick)
  );

  rs_debt #(.DEBT_MAX(DEBT_MAX), .URGENT_AT(URGENT_AT)) u_debt (
    .clk(clk), .rst_n(rst_n), .inc(tick), .dec(grant), .clear(sr_leave),
    .owed(owed), .urgent(urgent_lvl)
  );

  rs_window #(.LEN(TRFC_CYC)) u_rfc (
    .clk(clk), .rst_n(rst_n), .load(grant), .busy(rfc_busy)
  );
  rs_window #(.LEN(XSNR_CYC)) u_xsnr (
    .clk(clk), .rst_n(rst_n), .load(sr_leave), .busy(xsnr_busy)
  );
  rs_window #(.LEN(XSRD_CYC)) u_xsrd (
    .clk(clk), .rst_n(rst_n), .load(sr_leave), .busy(xsrd_busy)
  );

  always_comb begin
    state_nx = state;
    case (state)
      ST_IDLE: begin
        if (quiet) begin
          if (sr_enter) state_nx = ST_SRPRE;
          else if (owed) state_nx = ST_PRE;
        end
      end
      ST_PRE:   if (banks_idle) state_nx = ST_REQ;
      ST_REQ:   if (ref_gnt) state_nx = ST_IDLE;
      ST_SRPRE: if (banks_idle) state_nx = ST_SELF;
      ST_SELF:  if (sr_exit) state_nx = ST_IDLE;
      default:  state_nx = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state <= ST_IDLE;
    else state <= state_nx;
  end

  assign pre_req    = (state == ST_PRE) || (state == ST_SRPRE);
  assign ref_req    = (state == ST_REQ);
  assign cke        = (state != ST_SELF);
  assign act_block  = urgent_lvl && cke;
  assign ref_urgent = urgent_lvl && (pre_req || ref_req);
  assign cmd_block  = rfc_busy || xsnr_busy;
  assign read_block = cmd_block || xsrd_busy;
endmodule

// File: rtl/refresh_sched_chk.sv
module refresh_sched_chk (
  input logic clk,
  input logic rst_n,
  input logic banks_idle,
  input logic ref_gnt,
  input logic sr_enter,
  input logic sr_exit,
  input logic pre_req,
  input logic ref_req,
  input logic ref_urgent,
  input logic act_block,
  input logic cmd_block,
  input logic read_block,
  input logic cke
);
  a_r3_req_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    !(pre_req && ref_req));
  a_r3_ref_held: assert property (@(posedge clk) disable iff (!rst_n)
    (ref_req && !ref_gnt) |=> ref_req);
  a_r3_pre_held: assert property (@(posedge clk) disable iff (!rst_n)
    (pre_req && !banks_idle) |=> pre_req);
  a_r3_pre_to_ref: assert property (@(posedge clk) disable iff (!rst_n)
    (pre_req && banks_idle && cke && !act_block && !ref_urgent) |=> (ref_req || !cke));
  a_r7_quiet_while_blocked: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_block |-> (!pre_req && !ref_req && cke));
  a_r7_read_covers_cmd: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_block |-> read_block);
  a_r9_no_req_in_self: assert property (@(posedge clk) disable iff (!rst_n)
    !cke |-> (!pre_req && !ref_req && !act_block));
  a_r10_exit_windows: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cke) |-> (cmd_block && read_block));
  a_r6_urgent_blocks: assert property (@(posedge clk) disable iff (!rst_n)
    ref_urgent |-> act_block);
endmodule

bind refresh_sched refresh_sched_chk u_chk (.*);

// File: tb/refresh_sched_tb.sv
module refresh_sched_tb;
  localparam int CLK_PERIOD = 10;
  localparam int INTERVAL   = 20;
  localparam int DMAX       = 8;
  localparam int URG        = 7;
  localparam int TRFC       = 10;
  localparam int XSNR       = 10;
  localparam int XSRD       = 200;

  logic clk = 0, rst_n = 0;
  logic banks_idle = 1, ref_gnt = 0, sr_enter = 0, sr_exit = 0;
  logic pre_req, ref_req, ref_urgent, act_block, cmd_block, read_block, cke;

  int checks = 0, errors = 0;
  string phase = "R1";
  bit done = 0;

  // behavioural reference: 0 idle, 1 pre, 2 req, 3 sr-pre, 4 self
  int m_state = 0, m_debt = 0, m_tc = 0, m_rfc = 0, m_xsnr = 0, m_xsrd = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  refresh_sched #(.INTERVAL_CYC(INTERVAL), .DEBT_MAX(DMAX), .URGENT_AT(URG),
                  .TRFC_CYC(TRFC), .XSNR_CYC(XSNR), .XSRD_CYC(XSRD)) u_dut (
    .clk(clk), .rst_n(rst_n), .banks_idle(banks_idle), .ref_gnt(ref_gnt),
    .sr_enter(sr_enter), .sr_exit(sr_exit), .pre_req(pre_req), .ref_req(ref_req),
    .ref_urgent(ref_urgent), .act_block(act_block), .cmd_block(cmd_block),
    .read_block(read_block), .cke(cke));

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_state = 0; m_debt = 0; m_tc = 0; m_rfc = 0; m_xsnr = 0; m_xsrd = 0;
    end else begin
      bit tk, gr, quiet;
      int ns;
      tk = (m_state != 4) && (m_tc == INTERVAL - 1);
      gr = (m_state == 2) && ref_gnt;
      quiet = (m_rfc == 0) && (m_xsnr == 0);
      ns = m_state;
      case (m_state)
        0: if (quiet) begin if (sr_enter) ns = 3; else if (m_debt > 0) ns = 1; end
        1: if (banks_idle) ns = 2;
        2: if (ref_gnt) ns = 0;
        3: if (banks_idle) ns = 4;
        default: if (sr_exit) ns = 0;
      endcase
      if (m_rfc > 0) m_rfc--;
      if (m_xsnr > 0) m_xsnr--;
      if (m_xsrd > 0) m_xsrd--;
      if (gr) m_rfc = TRFC;
      if (m_state == 4 && sr_exit) begin
        m_debt = 0; m_tc = 0; m_xsnr = XSNR; m_xsrd = XSRD;
      end else begin
        m_debt = m_debt + (tk ? 1 : 0) - (gr ? 1 : 0);
        if (m_debt > DMAX) m_debt = DMAX;
        if (m_state != 4) m_tc = tk ? 0 : m_tc + 1;
      end
      m_state = ns;
    end
  end

  task automatic chk1(string name, logic act, logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual=%b expected=%b at %0t", phase, name, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n && !done) begin
      bit e_pre, e_ref, e_urg, e_cke, e_cmd;
      e_pre = (m_state == 1) || (m_state == 3);
      e_ref = (m_state == 2);
      e_cke = (m_state != 4);
      e_urg = (m_debt >= URG);
      e_cmd = (m_rfc > 0) || (m_xsnr > 0);
      chk1("pre_req", pre_req, e_pre);
      chk1("ref_req", ref_req, e_ref);
      chk1("ref_urgent", ref_urgent, e_urg && (e_pre || e_ref));
      chk1("act_block", act_block, e_urg && e_cke);
      chk1("cmd_block", cmd_block, e_cmd);
      chk1("read_block", read_block, e_cmd || (m_xsrd > 0));
      chk1("cke", cke, e_cke);
    end
  end

  task automatic finish_run();
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  task automatic step(int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    finish_run();
  end

  initial begin
    step(3);
    // R1: reset state, outputs examined while reset is held
    chk1("pre_req", pre_req, 0); chk1("ref_req", ref_req, 0);
    chk1("ref_urgent", ref_urgent, 0); chk1("act_block", act_block, 0);
    chk1("cmd_block", cmd_block, 0); chk1("read_block", read_block, 0);
    chk1("cke", cke, 1);
    rst_n = 1;
    step(2);
    // R2 and R4: periodic refresh with grants always available
    phase = "R2"; ref_gnt = 1; banks_idle = 1; step(100);
    // R8: grant held high while no request is pending
    phase = "R8"; step(15);
    // R3: banks busy holds precharge request, then no grant holds refresh request
    phase = "R3"; ref_gnt = 0; banks_idle = 0; step(25);
    banks_idle = 1; step(10);
    ref_gnt = 1; step(5);
    // R5 and R6: postpone beyond the cap, then drain
    phase = "R5"; ref_gnt = 0; step(220);
    phase = "R6"; step(5); ref_gnt = 1; step(300);
    // R11: wrong-state self-refresh controls
    phase = "R11"; ref_gnt = 0; banks_idle = 0;
    for (int i = 0; i < 200 && m_state != 1; i++) step(1);
    sr_enter = 1; sr_exit = 1; step(1);
    sr_enter = 0; step(2); sr_exit = 0;
    banks_idle = 1; ref_gnt = 1; step(30);
    // R9: self-refresh entry and frozen interval
    phase = "R9"; sr_enter = 1;
    for (int i = 0; i < 200 && m_state != 4; i++) step(1);
    sr_enter = 0; step(100);
    // R10: self-refresh exit windows and cleared debt
    phase = "R10"; sr_exit = 1; step(1); sr_exit = 0;
    step(250);
    // R7: a few more refreshes with slow bank idle
    phase = "R7"; banks_idle = 0; step(30); banks_idle = 1; step(60);
    finish_run();
  end
endmodule